// File: doc/BRIEF.md
# Flash Array Program/Erase Engine

This block is a compact, synthesizable model of a NOR-style storage array that behaves the way flash does rather than the way RAM does. Commands arrive already decoded on a request port: a command code, an address, a data byte and a valid strobe. Programming can only clear bits. A program stream is confined to one 256-byte page and wraps inside it. Erase returns a whole aligned region to all-ones, at one of four granularities. The busy output shows when an operation is under way, and the done output pulses when it ends.

Byte reads come back one cycle after the request. A read can continue linearly through the whole array, or it can wrap inside an aligned window of 8, 16, 32 or 64 bytes. The array is small by default (4 KB) and all region sizes are parameters, so a full erase sweep stays short in simulation. Erase visits one byte per cycle and then holds busy for a further BUSY_CYC cycles. A program operation holds busy for BUSY_CYC cycles after its stream is closed.

Command codes on req_cmd: 0 idle, 1 read, 2 wrapped read, 3 read next, 4 program open, 5 program data, 6 program close, 7 erase.

Top module: `flash_pe_engine`

## Requirements
- R1: Before any program operation, every address reads 0xFF. The array contents are not touched by reset.
- R2: A program-data byte is combined into the stored byte by bitwise AND, so a stored 0 bit never returns to 1 through programming.
- R3: A program open (code 4) takes the page from req_addr[ADDR_W-1:8] and the start column from req_addr[7:0]. Each program-data byte (code 5) goes to the current column, and the column then advances modulo 256 without changing the page.
- R4: An erase (code 7) selects its region with req_data[1:0]: 0 = 2^SECT_W bytes, 1 = 2^BLKA_W bytes, 2 = 2^BLKB_W bytes, 3 = the whole array. The region base is req_addr rounded down to the region size. Every byte in the region becomes 0xFF and all other bytes keep their value.
- R5: busy rises in the cycle after an accepted erase and stays high for region size + BUSY_CYC cycles. It also rises in the cycle after a program close (code 6) and stays high for BUSY_CYC cycles.
- R6: done is high for exactly one cycle, the first cycle in which busy is low again, and at no other time.
- R7: While busy is high, every request is ignored. While a program stream is open, only codes 5 and 6 have an effect, and a read request produces no rd_valid.
- R8: A read (code 1) from the idle state returns the byte at req_addr on rd_data, with rd_valid high in the next cycle. A read next (code 3) returns the byte at the following address, wrapping from the last address to 0.
- R9: A wrapped read (code 2) takes its window from req_data[1:0] (0:8, 1:16, 2:32, 3:64 bytes). It returns the byte at req_addr, and the read-next commands that follow step through the aligned window containing req_addr, returning to the window base after its top.
- R10: While reset (rst_n low) is asserted and right after it, busy, done and rd_valid are low and no program stream is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, one command per cycle |
| req_cmd | input | 3 | Command code |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | 8 | Program byte, or the size code for erase and wrapped read |
| busy | output | 1 | Program or erase operation in progress |
| done | output | 1 | One-cycle pulse when an operation finishes |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | 8 | Read byte |

## Verification
The assertions take it for granted that req_cmd, req_addr and req_data are stable across each rising edge whenever req_valid is high. They also assume BUSY_CYC is at least one and that every region exponent lies between the page width and ADDR_W. The stimulus drives every input on the falling edge and keeps the default parameters. It deliberately sends erase, read and program-open commands during busy and during an open program stream, because the design is required to drop them. The program-only-clears check relies on the array seeing at most one write per cycle, which the engine guarantees by serializing sweeps and program bytes.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [2:0] {
        CMD_NOP        = 3'd0,
        CMD_READ       = 3'd1,
        CMD_READ_WRAP  = 3'd2,
        CMD_READ_NEXT  = 3'd3,
        CMD_PROG_OPEN  = 3'd4,
        CMD_PROG_DATA  = 3'd5,
        CMD_PROG_CLOSE = 3'd6,
        CMD_ERASE      = 3'd7
    } fpe_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SWEEP = 2'd2,
        ST_HOLD  = 2'd3
    } fpe_state_e;

endpackage

// File: rtl/fpe_array.sv
module fpe_array #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              and_en,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= and_en ? (mem[waddr] & wdata) : wdata;
    end

    assign rdata = mem[raddr];

    // R2
    property clear_only_p;
        @(posedge clk) disable iff (!rst_n)
        (we && and_en) |=> ((mem[$past(waddr)] & ~$past(wdata)) == 8'h00);
    endproperty
    clear_only_chk: assert property (clear_only_p);

    // R4
    property erase_ones_p;
        @(posedge clk) disable iff (!rst_n)
        (we && !and_en && wdata == 8'hFF) |=> (mem[$past(waddr)] == 8'hFF);
    endproperty
    erase_ones_chk: assert property (erase_ones_p);

endmodule

// File: rtl/fpe_erase_span.sv
module fpe_erase_span #(
    parameter int ADDR_W = 12,
    parameter int SECT_W = 9,
    parameter int BLKA_W = 10,
    parameter int BLKB_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        gran,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] last
);
    localparam int NGRAN = 4;

    function automatic logic [ADDR_W-1:0] low_ones(input int w);
        logic [ADDR_W:0] one_hot;
        one_hot = (ADDR_W+1)'(1) << w;
        return ADDR_W'(one_hot - (ADDR_W+1)'(1));
    endfunction

    logic [ADDR_W-1:0] gran_mask [NGRAN];

    for (genvar g = 0; g < NGRAN; g++) begin : g_mask
        localparam int GW = (g == 0) ? SECT_W :
                            (g == 1) ? BLKA_W :
                            (g == 2) ? BLKB_W : ADDR_W;
        assign gran_mask[g] = low_ones(GW);
    end

    always_comb begin
        last = gran_mask[gran];
        base = addr & ~gran_mask[gran];
    end

endmodule

// File: rtl/fpe_read_step.sv
module fpe_read_step #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              wrap_en,
    input  logic [1:0]        code,
    output logic [ADDR_W-1:0] nxt
);
    logic [6:0]        win_m7;
    logic [ADDR_W-1:0] win_mask;
    logic [ADDR_W-1:0] plus1;

    always_comb begin
        win_m7   = (7'd8 << code) - 7'd1;
        win_mask = ADDR_W'(win_m7);
        plus1    = cur + ADDR_W'(1);
        nxt      = wrap_en ? ((cur & ~win_mask) | (plus1 & win_mask)) : plus1;
    end

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int PAGE_W   = 8,
    parameter int SECT_W   = 9,
    parameter int BLKA_W   = 10,
    parameter int BLKB_W   = 11,
    parameter int BUSY_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              busy,
    output logic              done,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    localparam int PG_W   = ADDR_W - PAGE_W;
    localparam int HOLD_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

    typedef struct packed {
        fpe_state_e        state;
        logic [PG_W-1:0]   page;
        logic [PAGE_W-1:0] col;
        logic [ADDR_W-1:0] sweep_ptr;
        logic [ADDR_W-1:0] sweep_left;
        logic [HOLD_W-1:0] hold_left;
        logic [ADDR_W-1:0] rd_ptr;
        logic              rd_wrap;
        logic [1:0]        rd_code;
        logic              rd_valid;
        logic [7:0]        rd_data;
        logic              done;
    } ctl_t;

    ctl_t c_d, c_q;

    fpe_cmd_e cmd;
    assign cmd = fpe_cmd_e'(req_cmd);

    logic              arr_we, arr_and;
    logic [ADDR_W-1:0] arr_waddr, arr_raddr;
    logic [7:0]        arr_wdata, arr_rdata;
    logic [ADDR_W-1:0] step_cur, step_nxt;
    logic              step_wrap;
    logic [1:0]        step_code;
    logic [ADDR_W-1:0] span_base, span_last;

    fpe_array #(.ADDR_W(ADDR_W)) array_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (arr_we),
        .and_en (arr_and),
        .waddr  (arr_waddr),
        .wdata  (arr_wdata),
        .raddr  (arr_raddr),
        .rdata  (arr_rdata)
    );

    fpe_read_step #(.ADDR_W(ADDR_W)) step_i (
        .cur     (step_cur),
        .wrap_en (step_wrap),
        .code    (step_code),
        .nxt     (step_nxt)
    );

    fpe_erase_span #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W),
        .BLKA_W (BLKA_W),
        .BLKB_W (BLKB_W)
    ) span_i (
        .addr (req_addr),
        .gran (req_data[1:0]),
        .base (span_base),
        .last (span_last)
    );

    // read-address selection, kept apart from the state update
    always_comb begin
        arr_raddr = c_q.rd_ptr;
        step_cur  = c_q.rd_ptr;
        step_wrap = c_q.rd_wrap;
        step_code = c_q.rd_code;
        if (cmd == CMD_READ || cmd == CMD_READ_WRAP) begin
            arr_raddr = req_addr;
            step_cur  = req_addr;
            step_wrap = (cmd == CMD_READ_WRAP);
            step_code = req_data[1:0];
        end
    end

    always_comb begin
        c_d          = c_q;
        c_d.done     = 1'b0;
        c_d.rd_valid = 1'b0;
        arr_we       = 1'b0;
        arr_and      = 1'b0;
        arr_waddr    = c_q.sweep_ptr;
        arr_wdata    = 8'hFF;
        case (c_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    case (cmd)
                        CMD_READ, CMD_READ_WRAP: begin
                            c_d.rd_valid = 1'b1;
                            c_d.rd_data  = arr_rdata;
                            c_d.rd_ptr   = step_nxt;
                            c_d.rd_wrap  = (cmd == CMD_READ_WRAP);
                            c_d.rd_code  = req_data[1:0];
                        end
                        CMD_READ_NEXT: begin
                            c_d.rd_valid = 1'b1;
                            c_d.rd_data  = arr_rdata;
                            c_d.rd_ptr   = step_nxt;
                        end
                        CMD_PROG_OPEN: begin
                            c_d.state = ST_LOAD;
                            c_d.page  = req_addr[ADDR_W-1:PAGE_W];
                            c_d.col   = req_addr[PAGE_W-1:0];
                        end
                        CMD_ERASE: begin
                            c_d.state      = ST_SWEEP;
                            c_d.sweep_ptr  = span_base;
                            c_d.sweep_left = span_last;
                        end
                        default: ;
                    endcase
                end
            end
            ST_LOAD: begin
                if (req_valid && cmd == CMD_PROG_DATA) begin
                    arr_we    = 1'b1;
                    arr_and   = 1'b1;
                    arr_waddr = {c_q.page, c_q.col};
                    arr_wdata = req_data;
                    c_d.col   = c_q.col + PAGE_W'(1);
                end else if (req_valid && cmd == CMD_PROG_CLOSE) begin
                    c_d.state     = ST_HOLD;
                    c_d.hold_left = HOLD_W'(BUSY_CYC - 1);
                end
            end
            ST_SWEEP: begin
                arr_we         = 1'b1;
                c_d.sweep_ptr  = c_q.sweep_ptr + ADDR_W'(1);
                c_d.sweep_left = c_q.sweep_left - ADDR_W'(1);
                if (c_q.sweep_left == '0) begin
                    c_d.state     = ST_HOLD;
                    c_d.hold_left = HOLD_W'(BUSY_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (c_q.hold_left == '0) begin
                    c_d.state = ST_IDLE;
                    c_d.done  = 1'b1;
                end else begin
                    c_d.hold_left = c_q.hold_left - HOLD_W'(1);
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy     = (c_q.state == ST_SWEEP) || (c_q.state == ST_HOLD);
    assign done     = c_q.done;
    assign rd_valid = c_q.rd_valid;
    assign rd_data  = c_q.rd_data;

    // R3
    property page_fixed_p;
        @(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_LOAD && $past(c_q.state == ST_LOAD)) |-> $stable(c_q.page);
    endproperty
    page_fixed_chk: assert property (page_fixed_p);

    // R6
    property done_edge_p;
        @(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy));
    endproperty
    done_edge_chk: assert property (done_edge_p);

    // R6
    property done_single_p;
        @(posedge clk) disable iff (!rst_n)
        done |=> !done;
    endproperty
    done_single_chk: assert property (done_single_p);

    // R7
    property hold_exit_p;
        @(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_HOLD) |=> (c_q.state == ST_HOLD || c_q.state == ST_IDLE);
    endproperty
    hold_exit_chk: assert property (hold_exit_p);

    // R8
    property rd_after_req_p;
        @(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(req_valid) && !$past(busy));
    endproperty
    rd_after_req_chk: assert property (rd_after_req_p);

endmodule

// File: tb/flash_pe_engine_tb.sv
module flash_pe_engine_tb_top;
    localparam int ADDR_W = 12;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BUSY_C = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_cmd = 3'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_data = 8'h00;
    logic              busy, done, rd_valid;
    logic [7:0]        rd_data;

    always #10 clk = ~clk;

    flash_pe_engine #(.ADDR_W(ADDR_W), .BUSY_CYC(BUSY_C)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // behavioural reference
    bit [7:0] ref_mem [DEPTH];
    int   m_busy_left = 0;
    bit   m_done = 0, m_rdv = 0, m_sess = 0, m_wrap = 0;
    bit [7:0] m_rdd = 0;
    int   m_ptr = 0, m_code = 0, m_page = 0, m_col = 0;

    int n_checks = 0, n_errors = 0;
    string phase = "R10";

    initial for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;

    function automatic int advance(int a, bit w, int code);
        int win;
        if (!w) return (a + 1) % DEPTH;
        win = 8 << code;
        return (a - (a % win)) + ((a + 1) % win);
    endfunction

    function automatic int region_size(int code);
        case (code)
            0: return 512;
            1: return 1024;
            2: return 2048;
            default: return DEPTH;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy_left = 0; m_done = 0; m_rdv = 0; m_sess = 0;
            m_ptr = 0; m_wrap = 0; m_code = 0;
        end else begin
            m_done = 0;
            m_rdv  = 0;
            if (m_busy_left > 0) begin
                m_busy_left--;
                if (m_busy_left == 0) m_done = 1;
            end else if (m_sess) begin
                if (req_valid && req_cmd == 3'd5) begin
                    ref_mem[m_page * 256 + m_col] &= req_data;
                    m_col = (m_col + 1) % 256;
                end else if (req_valid && req_cmd == 3'd6) begin
                    m_sess = 0;
                    m_busy_left = BUSY_C;
                end
            end else if (req_valid) begin
                case (req_cmd)
                    3'd1, 3'd2: begin
                        m_rdv  = 1;
                        m_rdd  = ref_mem[int'(req_addr)];
                        m_wrap = (req_cmd == 3'd2);
                        m_code = int'(req_data[1:0]);
                        m_ptr  = advance(int'(req_addr), m_wrap, m_code);
                    end
                    3'd3: begin
                        m_rdv = 1;
                        m_rdd = ref_mem[m_ptr];
                        m_ptr = advance(m_ptr, m_wrap, m_code);
                    end
                    3'd4: begin
                        m_sess = 1;
                        m_page = int'(req_addr) / 256;
                        m_col  = int'(req_addr) % 256;
                    end
                    3'd7: begin
                        int sz, b;
                        sz = region_size(int'(req_data[1:0]));
                        b  = int'(req_addr) - (int'(req_addr) % sz);
                        for (int i = 0; i < sz; i++) ref_mem[b + i] = 8'hFF;
                        m_busy_left = sz + BUSY_C;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic compare();
        n_checks++;
        if (busy !== (m_busy_left > 0)) begin
            n_errors++;
            $display("FAIL %s busy: actual=%0b expected=%0b", phase, busy, (m_busy_left > 0));
        end
        n_checks++;
        if (done !== m_done) begin
            n_errors++;
            $display("FAIL %s done: actual=%0b expected=%0b", phase, done, m_done);
        end
        n_checks++;
        if (rd_valid !== m_rdv) begin
            n_errors++;
            $display("FAIL %s rd_valid: actual=%0b expected=%0b", phase, rd_valid, m_rdv);
        end
        if (m_rdv) begin
            n_checks++;
            if (rd_data !== m_rdd) begin
                n_errors++;
                $display("FAIL %s rd_data: actual=%02h expected=%02h", phase, rd_data, m_rdd);
            end
        end
    endtask

    task automatic step(input bit v, input int c, input int a, input int d);
        @(negedge clk);
        compare();
        req_valid = v;
        req_cmd   = 3'(c);
        req_addr  = ADDR_W'(a);
        req_data  = 8'(d);
    endtask

    task automatic idle_until_free();
        step(0, 0, 0, 0);
        while (m_busy_left > 0) step(0, 0, 0, 0);
        step(0, 0, 0, 0);
    endtask

    task automatic program_run(input int a, input int n, input int seed);
        step(1, 4, a, 0);
        for (int i = 0; i < n; i++) step(1, 5, 0, (seed + i * 7) ^ 8'hA5);
        step(1, 6, 0, 0);
        idle_until_free();
    endtask

    task automatic read_run(input int a, input int wcode, input bit w, input int n);
        step(1, w ? 2 : 1, a, wcode);
        for (int i = 0; i < n; i++) step(1, 3, 0, 0);
        step(0, 0, 0, 0);
    endtask

    task automatic run_all();
        // R10: reset state
        repeat (3) step(0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) step(0, 0, 0, 0);

        // R1: erased array
        phase = "R1";
        read_run(0, 0, 0, 3);
        read_run(12'h7FF, 0, 0, 2);

        // R2 R3: program with page wrap
        phase = "R3";
        program_run(12'h1F0, 20, 3);
        read_run(12'h1F0, 0, 0, 16);
        read_run(12'h100, 0, 0, 5);
        phase = "R2";
        step(1, 4, 12'h1F4, 0);
        step(1, 5, 0, 8'h0F);
        step(1, 5, 0, 8'hFF);
        step(1, 5, 0, 8'hF0);
        step(1, 5, 0, 8'h3C);
        // R7: requests inside an open stream
        phase = "R7";
        step(1, 1, 12'h1F4, 0);
        step(1, 7, 12'h1F4, 3);
        step(1, 6, 0, 0);
        // R7: requests while busy
        step(1, 7, 0, 3);
        step(1, 4, 12'h500, 0);
        step(1, 1, 12'h1F4, 0);
        idle_until_free();
        phase = "R2";
        read_run(12'h1F0, 0, 0, 8);

        // R4: erase granularities
        phase = "R4";
        program_run(12'h200, 4, 11);
        program_run(12'h400, 4, 21);
        program_run(12'h800, 4, 31);
        phase = "R5";
        step(1, 7, 12'h1A3, 0);
        idle_until_free();
        phase = "R4";
        read_run(12'h1F0, 0, 0, 3);
        read_run(12'h100, 0, 0, 2);
        read_run(12'h200, 0, 0, 3);
        step(1, 7, 12'h2FF, 1);
        idle_until_free();
        read_run(12'h200, 0, 0, 3);
        read_run(12'h400, 0, 0, 3);
        step(1, 7, 12'h4AA, 2);
        idle_until_free();
        read_run(12'h400, 0, 0, 3);
        read_run(12'h800, 0, 0, 3);
        phase = "R6";
        step(1, 7, 12'h9CD, 3);
        idle_until_free();
        phase = "R4";
        read_run(12'h800, 0, 0, 3);

        // R9: wrapped reads across all window sizes
        phase = "R9";
        step(1, 4, 12'h300, 0);
        for (int i = 0; i < 256; i++) step(1, 5, 0, i);
        step(1, 6, 0, 0);
        idle_until_free();
        for (int c = 0; c < 4; c++) read_run(12'h33D, c, 1, 70);
        read_run(12'h307, 0, 1, 10);

        // R8: linear read across the top of the array
        phase = "R8";
        program_run(12'hFFE, 3, 50);
        program_run(12'h000, 2, 60);
        read_run(12'hFFE, 0, 0, 4);
        read_run(12'h33D, 0, 0, 6);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule